// File: doc/BRIEF.md
# Serial EEPROM Autoload Controller

This block pulls the contents of a small three-wire serial configuration EEPROM into the chip without software help. It starts by itself when reset is released, and again on a start pulse. It drives the memory's chip select, shift clock and serial input, and samples its serial output. A first probe access finds out whether the part uses 6-bit or 8-bit word addresses. The controller then reads the whole part, 64 or 256 words, in address order.

While reading, it keeps a wrapping 16-bit sum of every word and compares it with a fixed signature. The first sixteen words are held in a register file. Three fields decoded from that file are presented directly: a 48-bit station address, a PHY device type and a PHY management address. A one-cycle completion strobe marks the end of a load. The done level, the checksum flag and the decoded fields stay valid until the next load begins.

Every serial phase lasts a fixed number of microseconds. A prescaler, set in system clocks per microsecond, times these phases, so the same netlist runs at any core clock.

Top module: `eeprom_autoload`

## Requirements
- R1: While reset is held, and whenever no load is running, chip select, shift clock and serial data-in are all low, and the shift clock never goes high with chip select low.
- R2: Serial data-in changes only while the shift clock is low. Each high and each low clock phase inside an access lasts at least CLKS_PER_US*PHASE_US system clocks. Chip select falls only when the clock is low and was low in the cycle before.
- R3: Every access gives exactly 28 rising shift-clock edges between the rise and fall of chip select. The frame is sent MSB first: leading zeros, then the read opcode 1,1,0, then the word address, then 16 clocks during which data-out is sampled near the end of each high phase.
- R4: The first access after a start is a probe with an 8-bit all-zero address: one leading zero, the opcode in frame bits 26:24, and the address in bits 23:16. The wide-address flag is set when captured bits 27:17 are all ones and bit 16 is zero. Otherwise the part is treated as 64 words with 6-bit addresses, sent with three leading zeros.
- R5: After the probe, words 0 up to size-1 are each read exactly once, in increasing address order.
- R6: The checksum-ok output is high after a load when the 16-bit wrapping sum of all words equals the SIGNATURE parameter (default 0xBABA), and low otherwise.
- R7: A checksum mismatch does not shorten the load: every word is still read and done is still raised.
- R8: The read port returns words 0 to 15 of the part, indexed by cacheIdx, once the load has completed.
- R9: Station address byte i sits in stationAddr[8i+7:8i] and comes from word i/2: the low byte for even i, the high byte for odd i (words 0 to 2).
- R10: phyType equals bits 13:8 of word 6, and phyAddr equals bits 4:0 of word 6.
- R11: doneStrobe pulses for exactly one cycle per load. loadDone and checksum-ok stay high until the next start, which clears both. A start pulse received while a load is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; its release launches a load |
| start | input | 1 | One-cycle request to reload while idle |
| eeCs | output | 1 | EEPROM chip select, active high |
| eeSk | output | 1 | EEPROM shift clock |
| eeDi | output | 1 | Serial data into the EEPROM |
| eeDo | input | 1 | Serial data out of the EEPROM |
| doneStrobe | output | 1 | One-cycle pulse at the end of a load |
| loadDone | output | 1 | High from the end of a load until the next start |
| sumOk | output | 1 | Image sum matched the signature (valid while loadDone) |
| wideAddr | output | 1 | Part uses 8-bit addresses (256 words) |
| stationAddr | output | 48 | Station address, byte i in bits 8i+7:8i |
| phyType | output | 6 | PHY device type from word 6 |
| phyAddr | output | 5 | PHY management address from word 6 |
| cacheIdx | input | 4 | Cached word index for the read port |
| cacheWord | output | 16 | Cached word selected by cacheIdx |

## Verification
The bench builds the block with CLKS_PER_US=1, which makes each serial phase two system clocks. At that setting a full 256-word load fits easily in the run, alongside several 64-word loads. SIGNATURE and CACHE_WORDS keep their defaults. The bench therefore covers both address widths from the probe, a matching image and an image off by one, reloading the cache with different data, and a start request issued in the middle of a load.

// File: rtl/ee_autoload_pkg.sv
`timescale 1ns/1ps
package ee_autoload_pkg;
  localparam int WORD_W      = 16;
  localparam int LARGE_AW    = 8;
  localparam int SMALL_AW    = 6;
  localparam int OPC_W       = 3;
  localparam logic [OPC_W-1:0] READ_OPC = 3'b110;
  localparam int FRAME_W     = 1 + OPC_W + LARGE_AW + WORD_W;
  localparam int LARGE_WORDS = 1 << LARGE_AW;
  localparam int SMALL_WORDS = 1 << SMALL_AW;
  localparam int PHY_WORD    = 6;
  localparam int MAC_BYTES   = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEL, ST_LOW, ST_HIGH, ST_TAIL, ST_GAP
  } ee_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                clearAll;
    logic                loadFrame;
    logic                probe;
    logic [LARGE_AW-1:0] frameAddr;
    logic                shiftBit;
    logic                wordDone;
    logic                probeWord;
    logic [LARGE_AW-1:0] wordAddr;
  } ee_strobe_t;
endpackage

// File: rtl/ee_ctrl.sv
`timescale 1ns/1ps
module ee_ctrl
  import ee_autoload_pkg::*;
#(
  parameter int PHASE_CLKS = 200
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       wideAddr,
  output ee_strobe_t strobe,
  output logic       eeCs,
  output logic       eeSk,
  output logic       doneStrobe,
  output logic       loadDone
);
  localparam int PC_W  = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [PC_W-1:0]     PHASE_TOP = PC_W'(PHASE_CLKS - 1);
  localparam logic [BIT_W-1:0]    LAST_BIT  = BIT_W'(FRAME_W - 1);
  localparam logic [LARGE_AW-1:0] TOP_WIDE  = LARGE_AW'(LARGE_WORDS - 1);
  localparam logic [LARGE_AW-1:0] TOP_SMALL = LARGE_AW'(SMALL_WORDS - 1);

  ee_state_e           state;
  logic [PC_W-1:0]     phaseCnt;
  logic [BIT_W-1:0]    bitCnt;
  logic [LARGE_AW-1:0] wordAddr;
  logic                probing;
  logic                kick;
  logic                tick, goLoad, finish;
  logic [LARGE_AW-1:0] lastAddr;

  assign tick     = (state != ST_IDLE) && (phaseCnt == '0);
  assign goLoad   = (state == ST_IDLE) && (kick || start);
  assign lastAddr = wideAddr ? TOP_WIDE : TOP_SMALL;
  assign finish   = tick && (state == ST_GAP) && !probing && (wordAddr == lastAddr);

  always_comb begin
    strobe           = '0;
    strobe.clearAll  = goLoad;
    strobe.probe     = goLoad;
    strobe.loadFrame = goLoad || (tick && (state == ST_GAP) && !finish);
    strobe.frameAddr = (goLoad || probing) ? '0 : wordAddr + 1'b1;
    strobe.shiftBit  = tick && (state == ST_HIGH);
    strobe.wordDone  = tick && (state == ST_TAIL);
    strobe.probeWord = probing;
    strobe.wordAddr  = wordAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      bitCnt     <= '0;
      wordAddr   <= '0;
      probing    <= 1'b0;
      kick       <= 1'b1;
      loadDone   <= 1'b0;
      doneStrobe <= 1'b0;
    end else begin
      doneStrobe <= finish;
      if (goLoad) begin
        state    <= ST_SEL;
        phaseCnt <= PHASE_TOP;
        bitCnt   <= '0;
        wordAddr <= '0;
        probing  <= 1'b1;
        kick     <= 1'b0;
        loadDone <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (!tick) begin
          phaseCnt <= phaseCnt - 1'b1;
        end else begin
          phaseCnt <= PHASE_TOP;
          unique case (state)
            ST_SEL: begin
              state  <= ST_LOW;
              bitCnt <= '0;
            end
            ST_LOW:  state <= ST_HIGH;
            ST_HIGH: begin
              if (bitCnt == LAST_BIT) state <= ST_TAIL;
              else begin
                state  <= ST_LOW;
                bitCnt <= bitCnt + 1'b1;
              end
            end
            ST_TAIL: state <= ST_GAP;
            ST_GAP: begin
              if (finish) begin
                state    <= ST_IDLE;
                loadDone <= 1'b1;
              end else begin
                state <= ST_SEL;
                if (probing) probing <= 1'b0;
                else         wordAddr <= wordAddr + 1'b1;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign eeCs = (state == ST_SEL) || (state == ST_LOW) ||
                (state == ST_HIGH) || (state == ST_TAIL);
  assign eeSk = (state == ST_HIGH);
endmodule

// File: rtl/ee_datapath.sv
`timescale 1ns/1ps
module ee_datapath
  import ee_autoload_pkg::*;
#(
  parameter logic [WORD_W-1:0] SIGNATURE   = 16'hBABA,
  parameter int                CACHE_WORDS = 16,
  localparam int               CACHE_AW    = $clog2(CACHE_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ee_strobe_t          strobe,
  input  logic                eeDo,
  output logic                eeDi,
  output logic                wideAddr,
  output logic                sumMatch,
  input  logic [CACHE_AW-1:0] cacheIdx,
  output logic [WORD_W-1:0]   cacheWord,
  output logic [8*MAC_BYTES-1:0] stationAddr,
  output logic [5:0]          phyType,
  output logic [4:0]          phyAddr
);
  logic [FRAME_W-1:0] frame, txSr, rxSr;
  logic [WORD_W-1:0]  sum;
  logic [WORD_W-1:0]  cache [CACHE_WORDS];
  logic [WORD_W-1:0]  rxWord;

  assign rxWord = rxSr[WORD_W-1:0];

  always_comb begin
    frame = '0;
    if (strobe.probe || wideAddr) begin
      frame[WORD_W +: LARGE_AW]         = strobe.frameAddr;
      frame[WORD_W + LARGE_AW +: OPC_W] = READ_OPC;
    end else begin
      frame[WORD_W +: SMALL_AW]         = strobe.frameAddr[SMALL_AW-1:0];
      frame[WORD_W + SMALL_AW +: OPC_W] = READ_OPC;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr     <= '0;
      rxSr     <= '0;
      sum      <= '0;
      wideAddr <= 1'b0;
    end else begin
      if (strobe.loadFrame)     txSr <= frame;
      else if (strobe.shiftBit) txSr <= {txSr[FRAME_W-2:0], 1'b0};
      if (strobe.shiftBit)      rxSr <= {rxSr[FRAME_W-2:0], eeDo};
      if (strobe.clearAll) begin
        sum      <= '0;
        wideAddr <= 1'b0;
      end else if (strobe.wordDone) begin
        if (strobe.probeWord)
          wideAddr <= (&rxSr[FRAME_W-1:WORD_W+1]) && !rxSr[WORD_W];
        else
          sum <= sum + rxWord;
      end
    end
  end

  for (genvar g = 0; g < CACHE_WORDS; g++) begin : g_cache
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cache[g] <= '0;
      else if (strobe.clearAll) cache[g] <= '0;
      else if (strobe.wordDone && !strobe.probeWord &&
               strobe.wordAddr == LARGE_AW'(g))
        cache[g] <= rxWord;
    end
  end

  for (genvar b = 0; b < MAC_BYTES; b++) begin : g_mac
    assign stationAddr[8*b +: 8] = cache[b/2][8*(b%2) +: 8];
  end

  assign eeDi      = txSr[FRAME_W-1];
  assign sumMatch  = (sum == SIGNATURE);
  assign cacheWord = cache[cacheIdx];
  assign phyType   = cache[PHY_WORD][13:8];
  assign phyAddr   = cache[PHY_WORD][4:0];
endmodule

// File: rtl/eeprom_autoload.sv
`timescale 1ns/1ps
module eeprom_autoload
  import ee_autoload_pkg::*;
#(
  parameter int                CLKS_PER_US = 100,
  parameter int                PHASE_US    = 2,
  parameter logic [15:0]       SIGNATURE   = 16'hBABA,
  parameter int                CACHE_WORDS = 16,
  localparam int               PHASE_CLKS  = CLKS_PER_US * PHASE_US,
  localparam int               CACHE_AW    = $clog2(CACHE_WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  output logic                eeCs,
  output logic                eeSk,
  output logic                eeDi,
  input  logic                eeDo,
  output logic                doneStrobe,
  output logic                loadDone,
  output logic                sumOk,
  output logic                wideAddr,
  output logic [47:0]         stationAddr,
  output logic [5:0]          phyType,
  output logic [4:0]          phyAddr,
  input  logic [CACHE_AW-1:0] cacheIdx,
  output logic [15:0]         cacheWord
);
  ee_strobe_t strobe;
  logic       sumMatch;

  ee_ctrl #(.PHASE_CLKS(PHASE_CLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wideAddr(wideAddr),
    .strobe(strobe), .eeCs(eeCs), .eeSk(eeSk),
    .doneStrobe(doneStrobe), .loadDone(loadDone)
  );

  ee_datapath #(.SIGNATURE(SIGNATURE), .CACHE_WORDS(CACHE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eeDo(eeDo), .eeDi(eeDi),
    .wideAddr(wideAddr), .sumMatch(sumMatch), .cacheIdx(cacheIdx),
    .cacheWord(cacheWord), .stationAddr(stationAddr),
    .phyType(phyType), .phyAddr(phyAddr)
  );

  assign sumOk = loadDone && sumMatch;
endmodule

// File: rtl/ee_autoload_chk.sv
`timescale 1ns/1ps
module ee_autoload_chk (
  input logic clk,
  input logic rstN,
  input logic eeCs,
  input logic eeSk,
  input logic eeDi,
  input logic doneStrobe,
  input logic loadDone,
  input logic sumOk
);
  // R2
  di_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eeSk && $past(eeSk)) |-> $stable(eeDi));
  // R2
  cs_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeCs) |-> (!eeSk && !$past(eeSk)));
  // R1
  sk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeSk);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);
  // R11
  done_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (loadDone && !eeCs));
  // R6
  valid_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    sumOk |-> loadDone);
endmodule

bind eeprom_autoload ee_autoload_chk u_chk (
  .clk(clk), .rstN(rstN), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
  .doneStrobe(doneStrobe), .loadDone(loadDone), .sumOk(sumOk)
);

// File: tb/eeprom_autoload_bench.sv
`timescale 1ns/1ps
module eeprom_autoload_bench;
  localparam int CPU        = 1;
  localparam int PHASE_CLKS = CPU * 2;
  localparam int FRAME_BITS = 28;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, start, eeCs, eeSk, eeDi, eeDo;
  logic doneStrobe, loadDone, sumOk, wideAddr;
  logic [47:0] stationAddr;
  logic [5:0]  phyType;
  logic [4:0]  phyAddr;
  logic [3:0]  cacheIdx;
  logic [15:0] cacheWord;

  eeprom_autoload #(.CLKS_PER_US(CPU)) u_eeprom_autoload (
    .clk(clk), .rstN(rstN), .start(start), .eeCs(eeCs), .eeSk(eeSk),
    .eeDi(eeDi), .eeDo(eeDo), .doneStrobe(doneStrobe), .loadDone(loadDone),
    .sumOk(sumOk), .wideAddr(wideAddr), .stationAddr(stationAddr),
    .phyType(phyType), .phyAddr(phyAddr), .cacheIdx(cacheIdx),
    .cacheWord(cacheWord)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural serial memory
  logic [15:0] mem [256];
  int  modelAw = 6;
  int  mState = 0, mCnt = 0, mAddr = 0, mOp = 0, edgeCnt = 0;
  logic mDo = 1'b1;
  int  readLog[$];
  assign eeDo = mDo;

  always @(posedge eeSk) begin
    if (eeCs) begin
      edgeCnt++;
      case (mState)
        0: if (eeDi) begin mState = 1; mCnt = 0; mOp = 0; end
        1: begin
          mOp = mOp * 2 + int'(eeDi); mCnt++;
          if (mCnt == 2) begin mState = 2; mCnt = 0; mAddr = 0; end
        end
        2: begin
          mAddr = mAddr * 2 + int'(eeDi); mCnt++;
          if (mCnt == modelAw) begin
            chk(mOp == 2, "R3", "read opcode", mOp, 2);
            readLog.push_back(mAddr);
            mDo = 1'b0; mState = 3; mCnt = 16;
          end
        end
        3: begin
          mDo = mem[mAddr][mCnt-1]; mCnt--;
          if (mCnt == 0) mState = 4;
        end
        default: mDo = 1'b1;
      endcase
    end
  end

  // per-clock protocol monitor
  logic prevCs = 1'b0, prevSk = 1'b0, prevDi = 1'b0, diMoved = 1'b0;
  int   runLen = 0;
  int   doneCount = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (doneStrobe) doneCount++;
      if (!eeCs && eeSk) chk(1'b0, "R1", "clock high without select", 1, 0);
      if (eeCs && !prevCs) begin edgeCnt = 0; runLen = 1; end
      else if (eeCs && prevCs && eeSk != prevSk) begin
        chk(runLen >= PHASE_CLKS, "R2", "phase width", runLen, PHASE_CLKS);
        runLen = 1;
      end else runLen++;
      if (eeSk && prevSk && eeDi != prevDi) diMoved = 1'b1;
      if (!eeSk && prevSk) begin
        chk(!diMoved, "R2", "data-in held while clock high", diMoved, 0);
        diMoved = 1'b0;
      end
      if (!eeCs && prevCs) begin
        chk(!eeSk && !prevSk, "R2", "select drop with clock low", prevSk, 0);
        chk(edgeCnt == FRAME_BITS, "R3", "clock edges per access", edgeCnt, FRAME_BITS);
        mState = 0; mDo = 1'b1;
      end
    end
    prevCs = eeCs; prevSk = eeSk; prevDi = eeDi;
  end

  task automatic fillImage(input int aw, input bit good, input int seed);
    logic [31:0] x;
    logic [15:0] s;
    int words;
    x = 32'(seed) * 32'h9E3779B9 + 32'h1234;
    words = 1 << aw;
    s = '0;
    for (int i = 0; i < 256; i++) begin
      x = x * 32'd1103515245 + 32'd12345;
      mem[i] = x[23:8];
    end
    for (int i = 0; i < words - 1; i++) s = s + mem[i];
    mem[words-1] = 16'hBABA - s + (good ? 16'h0 : 16'h1);
    modelAw = aw;
  endtask

  task automatic pulseStart();
    readLog.delete();
    doneCount = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(!loadDone && !sumOk, "R11", "start clears done and valid",
        {loadDone, sumOk}, 0);
  endtask

  task automatic waitDone();
    int n = 0;
    while (!loadDone && n < 40000) begin
      @(negedge clk); n++;
    end
    chk(loadDone, "R11", "load finished before watchdog", n, 40000);
    repeat (60) @(negedge clk);
    chk(loadDone, "R11", "done level held", loadDone, 1);
    chk(!eeCs && !eeSk && !eeDi, "R1", "serial lines idle after load",
        {eeCs, eeSk, eeDi}, 0);
  endtask

  task automatic verify(input int aw, input bit good);
    int words, mism;
    words = 1 << aw;
    chk(wideAddr == (aw == 8), "R4", "address width flag", wideAddr, aw == 8);
    chk(sumOk == good, "R6", "checksum flag", sumOk, good);
    mism = 0;
    if (readLog.size() != words + 1) mism++;
    else begin
      if (readLog[0] != 0) mism++;
      for (int i = 0; i < words; i++) if (readLog[i+1] != i) mism++;
    end
    chk(mism == 0, "R5", "probe then every word in order", readLog.size(), words + 1);
    if (!good)
      chk(mism == 0 && loadDone, "R7", "bad image still fully read",
          readLog.size(), words + 1);
    for (int k = 0; k < 16; k++) begin
      cacheIdx = 4'(k);
      @(negedge clk);
      chk(cacheWord == mem[k], "R8", $sformatf("cached word %0d", k), cacheWord, mem[k]);
    end
    chk(stationAddr == {mem[2], mem[1], mem[0]}, "R9", "station address",
        stationAddr, {mem[2], mem[1], mem[0]});
    chk(phyType == mem[6][13:8], "R10", "phy type", phyType, mem[6][13:8]);
    chk(phyAddr == mem[6][4:0], "R10", "phy address", phyAddr, mem[6][4:0]);
    chk(doneCount == 1, "R11", "one done pulse per load", doneCount, 1);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; cacheIdx = '0;
    fillImage(6, 1'b1, 1);
    repeat (3) @(negedge clk);
    chk(!eeCs && !eeSk && !eeDi && !loadDone && !doneStrobe, "R1",
        "reset state", {eeCs, eeSk, eeDi, loadDone, doneStrobe}, 0);
    readLog.delete(); doneCount = 0;
    rstN = 1'b1;
    waitDone(); verify(6, 1'b1);

    fillImage(8, 1'b1, 2);
    pulseStart(); waitDone(); verify(8, 1'b1);

    fillImage(6, 1'b0, 3);
    pulseStart();
    repeat (3000) @(negedge clk);
    start = 1'b1; @(negedge clk) start = 1'b0;  // R11: ignored while busy
    waitDone(); verify(6, 1'b0);

    fillImage(6, 1'b1, 4);
    pulseStart(); waitDone(); verify(6, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R11", "global watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule